// File: doc/BRIEF.md
# SPI Offload Register and Interrupt Front End

This block is the software-facing side of a command-driven SPI master. A simple 32-bit register bus (write strobe, read strobe, byte address, write data, registered read data) reaches a version word, a soft-reset control, interrupt enable, pending and source registers, and the ID of the last completed sync point. Three internal queues carry traffic between software and the SPI command executor: a command queue and a transmit-data queue written by software and drained by the executor, and a receive-data queue filled by the executor and drained by software.

Software reads the free room of the two outbound queues and the fill level of the inbound queue, pushes words by writing to fixed addresses, and either pops or peeks the receive queue. The executor signals the end of each command stream with a sync event that carries an 8-bit ID. That event latches the ID and raises a sticky pending bit, so software can match a completion to the program it queued. The pending bits for the queue watermarks follow the queue levels and need no clearing. A single level interrupt output is high while any enabled pending bit is high.

Top module: `spi_offload_regs`

## Requirements
- R1: Reading address 0x00 returns major version 1 in bits 23:16, the minor version parameter in bits 15:8, the patch parameter in bits 7:0 and zero in bits 31:24.
- R2: Address 0xD0 reads DEPTH minus the command queue level, 0xD4 reads DEPTH minus the transmit queue level, and 0xD8 reads the receive queue level.
- R3: A write to 0xE0 (command, bits 15:0) or to 0xE4 (transmit data, bits 31:0) while that queue is full is dropped, and the stored words are unchanged.
- R4: Command and transmit words reach the executor in the order written, presented on cmd_data/tx_data with a valid flag and removed on valid and ready.
- R5: A read of 0xE8 returns the receive queue head and removes it. A read of 0xEC returns the head and leaves the level unchanged. Either read on an empty queue returns 0 and leaves the level at 0.
- R6: Pending bit 0 is high while the command level is at most DEPTH/4, bit 1 while the transmit level is at most DEPTH/4, and bit 2 while the receive level is at least 3*DEPTH/4. Writes to address 0x84 do not change these bits.
- R7: A sync event stores sync_id at address 0xC0 (bits 7:0) and sets pending bit 3. A sync event in the same cycle as a clear of bit 3 leaves bit 3 set.
- R8: Writing 0x84 with bit 3 high clears pending bit 3. Writing it with bit 3 low leaves bit 3 unchanged.
- R9: Address 0x80 holds the enable bits 3:0. Address 0x88 reads pending AND enable, and irq is high exactly when that value is nonzero.
- R10: Bit 0 of address 0x40 is a readable soft reset, 0 after reset. While it is 1, engine_rst is high, all three queues are empty, and queue writes and receive pushes are dropped. Writing 0 releases it.
- R11: A read strobe gives reg_rvalid and the read data one cycle later. Unmapped addresses read 0.
- R12: rx_ready is low while the receive queue is full, and a word is stored only on rx_valid with rx_ready high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| cmd_valid | output | 1 | Command queue not empty |
| cmd_data | output | CMD_W | Command queue head |
| cmd_ready | input | 1 | Executor takes the command head |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_data | output | DATA_W | Transmit queue head |
| tx_ready | input | 1 | Executor takes the transmit head |
| rx_valid | input | 1 | Executor offers a received word |
| rx_data | input | DATA_W | Received word |
| rx_ready | output | 1 | Receive queue can accept a word |
| sync_valid | input | 1 | Sync point completed |
| sync_id | input | 8 | ID of the completed sync point |
| irq | output | 1 | Level interrupt |
| engine_rst | output | 1 | Soft reset to the executor |

## Verification
The assertions assume that reg_wr and reg_rd are never high together, that reg_addr is stable while either strobe is high, and that the executor asserts sync_valid for single cycles only. The bench drives each bus access as a one-cycle strobe from a task that sets only one of the two strobes. It raises sync_valid for exactly one cycle at a time. It keeps the executor ready inputs low except during explicit drain steps, so the queue levels seen by software are known at each read.

// File: rtl/spo_pkg.sv
// Package: address map and interrupt bit positions shared by the front end.
// Assumes byte addressing on an 8-bit offset with 32-bit aligned registers.
package spo_pkg;
    localparam logic [7:0] A_VERSION  = 8'h00;
    localparam logic [7:0] A_SOFTRST  = 8'h40;
    localparam logic [7:0] A_IRQ_EN   = 8'h80;
    localparam logic [7:0] A_IRQ_PEND = 8'h84;
    localparam logic [7:0] A_IRQ_SRC  = 8'h88;
    localparam logic [7:0] A_SYNC_ID  = 8'hC0;
    localparam logic [7:0] A_CMD_ROOM = 8'hD0;
    localparam logic [7:0] A_TX_ROOM  = 8'hD4;
    localparam logic [7:0] A_RX_LEVEL = 8'hD8;
    localparam logic [7:0] A_CMD_PUSH = 8'hE0;
    localparam logic [7:0] A_TX_PUSH  = 8'hE4;
    localparam logic [7:0] A_RX_POP   = 8'hE8;
    localparam logic [7:0] A_RX_PEEK  = 8'hEC;

    localparam int IB_CMD_LOW  = 0;
    localparam int IB_TX_LOW   = 1;
    localparam int IB_RX_HIGH  = 2;
    localparam int IB_SYNC     = 3;
    localparam int N_IRQ       = 4;

    localparam logic [7:0] VER_MAJOR = 8'd1;
endpackage

// File: rtl/spo_fifo.sv
// Module: spo_fifo - synchronous first-in first-out queue.
// Assumes DEPTH is a power of two. Push on full and pop on empty are
// ignored; clr empties the queue and wins over push and pop.
module spo_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH):0]     level
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == LW'(DEPTH));
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = mem[rd_ptr];
    assign level   = cnt;

    // Storage write on accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (level == LW'(DEPTH))); // R3
    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH)); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty); // R5
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty); // R10
endmodule

// File: rtl/spo_irq.sv
// Module: spo_irq - pending, source and interrupt logic.
// Watermark bits follow the queue levels; the sync bit is sticky and is
// set by a one-cycle sync event, which wins over a same-cycle clear.
module spo_irq #(
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(DEPTH):0]        cmd_level,
    input  logic [$clog2(DEPTH):0]        tx_level,
    input  logic [$clog2(DEPTH):0]        rx_level,
    input  logic                          sync_valid,
    input  logic [7:0]                    sync_id,
    input  logic                          ack_sync,
    input  logic [spo_pkg::N_IRQ-1:0]     enable,
    output logic [spo_pkg::N_IRQ-1:0]     pending,
    output logic [7:0]                    sync_id_q,
    output logic                          irq
);
    import spo_pkg::*;
    localparam int LW    = $clog2(DEPTH) + 1;
    localparam int LOW_TH  = DEPTH / 4;
    localparam int HIGH_TH = (3 * DEPTH) / 4;

    logic sync_pend;

    // Sticky sync flag and ID capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_pend <= 1'b0;
            sync_id_q <= '0;
        end else if (sync_valid) begin
            sync_pend <= 1'b1;
            sync_id_q <= sync_id;
        end else if (ack_sync) begin
            sync_pend <= 1'b0;
        end
    end

    // Pending vector from watermarks and the sync flag.
    always_comb begin
        pending              = '0;
        pending[IB_CMD_LOW]  = (cmd_level <= LW'(LOW_TH));
        pending[IB_TX_LOW]   = (tx_level  <= LW'(LOW_TH));
        pending[IB_RX_HIGH]  = (rx_level  >= LW'(HIGH_TH));
        pending[IB_SYNC]     = sync_pend;
    end

    assign irq = |(pending & enable);

    AST_SYNC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        sync_valid |=> (pending[IB_SYNC] && sync_id_q == $past(sync_id))); // R7
    AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_sync && !sync_valid) |=> !pending[IB_SYNC]); // R8
    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pending[IB_SYNC] && !ack_sync) |=> pending[IB_SYNC]); // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq); // R9
endmodule

// File: rtl/spi_offload_regs.sv
// Module: spi_offload_regs - register front end of a command-driven SPI
// master. Decodes a simple strobe bus, owns the command, transmit and
// receive queues and the interrupt logic. Assumes reg_wr and reg_rd are
// never high together and CMD_W < 32, DATA_W <= 32, DEPTH a power of two.
module spi_offload_regs #(
    parameter int         DEPTH     = 16,
    parameter int         CMD_W     = 16,
    parameter int         DATA_W    = 32,
    parameter logic [7:0] VER_MINOR = 8'h00,
    parameter logic [7:0] VER_PATCH = 8'h61
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_data,
    input  logic              cmd_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    input  logic              sync_valid,
    input  logic [7:0]        sync_id,
    output logic              irq,
    output logic              engine_rst
);
    import spo_pkg::*;
    localparam int LW = $clog2(DEPTH) + 1;

    logic                soft_q;
    logic [N_IRQ-1:0]    en_q;
    logic [N_IRQ-1:0]    pending;
    logic [7:0]          sync_id_q;
    logic [LW-1:0]       cmd_level, tx_level, rx_level;
    logic                cmd_empty, cmd_full, tx_empty, tx_full, rx_empty, rx_full;
    logic [DATA_W-1:0]   rx_head;
    logic [31:0]         rd_mux;
    logic                rx_head_rd;
    logic                unused_wbits;

    assign unused_wbits = ^reg_wdata[31:CMD_W];
    assign engine_rst   = soft_q;
    assign cmd_valid    = !cmd_empty;
    assign tx_valid     = !tx_empty;
    assign rx_ready     = !rx_full && !soft_q;
    assign rx_head_rd   = reg_rd && (reg_addr == A_RX_POP || reg_addr == A_RX_PEEK);

    // Control registers: soft reset and interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= 1'b0;
            en_q   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_SOFTRST) soft_q <= reg_wdata[0];
            if (reg_addr == A_IRQ_EN)  en_q   <= reg_wdata[N_IRQ-1:0];
        end
    end

    spo_fifo #(.W(CMD_W), .DEPTH(DEPTH)) i_cmd_q (
        .clk(clk), .rst_n(rst_n), .clr(soft_q),
        .push(reg_wr && reg_addr == A_CMD_PUSH), .din(reg_wdata[CMD_W-1:0]),
        .pop(cmd_valid && cmd_ready), .dout(cmd_data),
        .empty(cmd_empty), .full(cmd_full), .level(cmd_level));

    spo_fifo #(.W(DATA_W), .DEPTH(DEPTH)) i_tx_q (
        .clk(clk), .rst_n(rst_n), .clr(soft_q),
        .push(reg_wr && reg_addr == A_TX_PUSH), .din(reg_wdata[DATA_W-1:0]),
        .pop(tx_valid && tx_ready), .dout(tx_data),
        .empty(tx_empty), .full(tx_full), .level(tx_level));

    spo_fifo #(.W(DATA_W), .DEPTH(DEPTH)) i_rx_q (
        .clk(clk), .rst_n(rst_n), .clr(soft_q),
        .push(rx_valid && rx_ready), .din(rx_data),
        .pop(reg_rd && reg_addr == A_RX_POP), .dout(rx_head),
        .empty(rx_empty), .full(rx_full), .level(rx_level));

    spo_irq #(.DEPTH(DEPTH)) i_irq (
        .clk(clk), .rst_n(rst_n),
        .cmd_level(cmd_level), .tx_level(tx_level), .rx_level(rx_level),
        .sync_valid(sync_valid), .sync_id(sync_id),
        .ack_sync(reg_wr && reg_addr == A_IRQ_PEND && reg_wdata[IB_SYNC]),
        .enable(en_q), .pending(pending), .sync_id_q(sync_id_q), .irq(irq));

    // Read-data selection by address.
    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            A_VERSION:  rd_mux = {8'h00, VER_MAJOR, VER_MINOR, VER_PATCH};
            A_SOFTRST:  rd_mux = {31'd0, soft_q};
            A_IRQ_EN:   rd_mux = 32'(en_q);
            A_IRQ_PEND: rd_mux = 32'(pending);
            A_IRQ_SRC:  rd_mux = 32'(pending & en_q);
            A_SYNC_ID:  rd_mux = {24'd0, sync_id_q};
            A_CMD_ROOM: rd_mux = 32'(LW'(DEPTH) - cmd_level);
            A_TX_ROOM:  rd_mux = 32'(LW'(DEPTH) - tx_level);
            A_RX_LEVEL: rd_mux = 32'(rx_level);
            A_RX_POP,
            A_RX_PEEK:  rd_mux = rx_empty ? 32'd0 : 32'(rx_head);
            default:    rd_mux = '0;
        endcase
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) reg_rdata <= rd_mux;
        end
    end

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid); // R11
    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_head_rd && rx_empty) |=> (reg_rdata == 32'd0)); // R5
    AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_RX_PEEK && !(rx_valid && rx_ready) && !soft_q)
        |=> $stable(rx_level)); // R5
    AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(soft_q) && soft_q) |-> (!cmd_valid && !tx_valid && !rx_ready)); // R10
    AST_RX_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !rx_ready); // R12
endmodule

// File: tb/test_spi_offload_regs.sv
`timescale 1ns/1ps
module test_spi_offload_regs;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        cmd_valid, tx_valid, rx_ready, irq, engine_rst;
    logic [15:0] cmd_data;
    logic [31:0] tx_data;
    logic        cmd_ready = 1'b0, tx_ready = 1'b0, rx_valid = 1'b0, sync_valid = 1'b0;
    logic [31:0] rx_data = '0;
    logic [7:0]  sync_id = '0;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [31:0] cmdq[$], txq[$], rxq[$];
    bit sync_m = 1'b0;
    logic [3:0] en_m = '0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    spi_offload_regs #(.DEPTH(D)) i_spi_offload_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .sync_valid(sync_valid), .sync_id(sync_id),
        .irq(irq), .engine_rst(engine_rst));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_pend();
        return {sync_m, rxq.size() >= 6, txq.size() <= 2, cmdq.size() <= 2};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0;
        chk(reg_rvalid === 1'b1, "R11 rvalid", 32'(reg_rvalid), 32'd1);
        d = reg_rdata;
    endtask

    task automatic push_cmd(input logic [15:0] v);
        wr(8'hE0, {16'hDEAD, v});
        if (cmdq.size() < D) cmdq.push_back(32'(v));
    endtask

    task automatic push_tx(input logic [31:0] v);
        wr(8'hE4, v);
        if (txq.size() < D) txq.push_back(v);
    endtask

    task automatic drain_cmd();
        @(negedge clk);
        if (cmdq.size() == 0) chk(!cmd_valid, "R4 cmd idle", 32'(cmd_valid), 32'd0);
        else begin
            chk(cmd_valid && cmd_data == cmdq[0][15:0], "R4 cmd order", 32'(cmd_data), cmdq[0]);
            void'(cmdq.pop_front());
        end
        cmd_ready = 1'b1;
        @(negedge clk); cmd_ready = 1'b0;
    endtask

    task automatic drain_tx();
        @(negedge clk);
        if (txq.size() == 0) chk(!tx_valid, "R4 tx idle", 32'(tx_valid), 32'd0);
        else begin
            chk(tx_valid && tx_data == txq[0], "R4 tx order", tx_data, txq[0]);
            void'(txq.pop_front());
        end
        tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
    endtask

    task automatic push_rx(input logic [31:0] v);
        @(negedge clk);
        chk(rx_ready == (rxq.size() < D), "R12 rx_ready", 32'(rx_ready), 32'(rxq.size() < D));
        rx_valid = 1'b1; rx_data = v;
        @(negedge clk); rx_valid = 1'b0;
        if (rxq.size() < D) rxq.push_back(v);
    endtask

    task automatic pop_rx(input bit peek);
        logic [31:0] e;
        e = (rxq.size() == 0) ? 32'd0 : rxq[0];
        rd(peek ? 8'hEC : 8'hE8, rv);
        chk(rv == e, "R5 rx head", rv, e);
        if (!peek && rxq.size() != 0) void'(rxq.pop_front());
    endtask

    task automatic check_levels();
        rd(8'hD0, rv); chk(rv == 32'(D - cmdq.size()), "R2 cmd room", rv, 32'(D - cmdq.size()));
        rd(8'hD4, rv); chk(rv == 32'(D - txq.size()), "R2 tx room", rv, 32'(D - txq.size()));
        rd(8'hD8, rv); chk(rv == 32'(rxq.size()), "R2 rx level", rv, 32'(rxq.size()));
    endtask

    task automatic check_pend();
        rd(8'h84, rv); chk(rv == 32'(exp_pend()), "R6 pending", rv, 32'(exp_pend()));
        rd(8'h88, rv); chk(rv == 32'(exp_pend() & en_m), "R9 source", rv, 32'(exp_pend() & en_m));
        chk(irq == |(exp_pend() & en_m), "R9 irq", 32'(irq), 32'(|(exp_pend() & en_m)));
    endtask

    task automatic sync_pulse(input logic [7:0] id);
        @(negedge clk); sync_valid = 1'b1; sync_id = id;
        @(negedge clk); sync_valid = 1'b0;
        sync_m = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        rd(8'h00, rv); chk(rv == 32'h0001_0061, "R1 version", rv, 32'h0001_0061);
        rd(8'h40, rv); chk(rv == 32'd0, "R10 soft reset idle", rv, 32'd0);
        rd(8'h10, rv); chk(rv == 32'd0, "R11 unmapped", rv, 32'd0);
        chk(engine_rst == 1'b0, "R10 engine_rst", 32'(engine_rst), 32'd0);
        check_levels();
        check_pend();
        // Command queue fill past full, then drain in order
        for (int i = 0; i < D + 2; i++) begin
            push_cmd(16'(16'h100 + i));
            if (i == 2) check_pend();
        end
        check_levels();
        check_pend();
        for (int i = 0; i < D + 1; i++) drain_cmd();
        // Transmit queue
        for (int i = 0; i < D + 1; i++) push_tx($urandom);
        check_levels();
        for (int i = 0; i < 5; i++) drain_tx();
        check_pend();
        for (int i = 0; i < 5; i++) drain_tx();
        // Receive queue, watermarks, peek and pop
        for (int i = 0; i < 6; i++) push_rx($urandom);
        check_levels();
        wr(8'h84, 32'h7);
        check_pend();
        pop_rx(1'b1); pop_rx(1'b1);
        check_levels();
        pop_rx(1'b0); pop_rx(1'b0);
        check_levels();
        for (int i = 0; i < 6; i++) push_rx($urandom);
        check_levels();
        for (int i = 0; i < D + 1; i++) pop_rx(1'b0);
        pop_rx(1'b1);
        check_levels();
        // Sync events and interrupt enables
        wr(8'h80, 32'h8); en_m = 4'h8;
        rd(8'h80, rv); chk(rv == 32'h8, "R9 enable readback", rv, 32'h8);
        check_pend();
        sync_pulse(8'hA5);
        rd(8'hC0, rv); chk(rv == 32'hA5, "R7 sync id", rv, 32'hA5);
        check_pend();
        wr(8'h84, 32'h7); check_pend();
        wr(8'h84, 32'h8); sync_m = 1'b0; check_pend();
        @(negedge clk); sync_valid = 1'b1; sync_id = 8'h3C; reg_wr = 1'b1; reg_addr = 8'h84; reg_wdata = 32'h8;
        @(negedge clk); sync_valid = 1'b0; reg_wr = 1'b0; sync_m = 1'b1;
        check_pend();
        rd(8'hC0, rv); chk(rv == 32'h3C, "R7 sync id collision", rv, 32'h3C);
        wr(8'h84, 32'hFF); sync_m = 1'b0;
        wr(8'h80, 32'hF); en_m = 4'hF;
        check_pend();
        // Soft reset
        for (int i = 0; i < 3; i++) push_cmd(16'(i));
        push_tx(32'h55); push_rx(32'h66);
        wr(8'h40, 32'h1);
        cmdq.delete(); txq.delete(); rxq.delete();
        rd(8'h40, rv); chk(rv == 32'd1, "R10 soft readback", rv, 32'd1);
        chk(engine_rst && !cmd_valid && !tx_valid && !rx_ready, "R10 held",
            {28'd0, engine_rst, cmd_valid, tx_valid, rx_ready}, 32'h8);
        wr(8'hE0, 32'h1); wr(8'hE4, 32'h2);
        @(negedge clk); rx_valid = 1'b1; @(negedge clk); rx_valid = 1'b0;
        check_levels();
        wr(8'h40, 32'h0);
        chk(!engine_rst, "R10 release", 32'(engine_rst), 32'd0);
        check_levels();
        // Constrained random mix
        for (int it = 0; it < 400; it++) begin
            case ($urandom_range(0, 7))
                0: push_cmd(16'($urandom));
                1: drain_cmd();
                2: push_tx($urandom);
                3: drain_tx();
                4: push_rx($urandom);
                5: pop_rx(1'($urandom_range(0, 1)));
                6: check_pend();
                default: check_levels();
            endcase
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule